// File: doc/BRIEF.md
# Bus-phase decoded RAM with graphics-side passthrough

This block is a word-wide memory slave for a multiplexed address/data bus. The bus master steers it with phase strobes. An address phase captures the word currently on the shared bus as the target address. A read phase returns data for that address, and a write phase stores the bus word. A combined phase captures a new address just as the address phase does, but it never returns data. All strobes are sampled on the rising edge of `clk`. Read data is combinational from the captured address and the read strobe, so it is valid while the strobe is high.

The decoder splits the 16-bit address space into four kinds of region:
- **Storage window.** A 512-word window at 0x0200 selects the internal array. Only its lower 352 words (0x0200–0x035F) hold data. The rest of the window (0x0360–0x03FF) answers reads with all ones.
- **Passthrough windows.** Two windows, 0x0000–0x007F and 0x3000–0x3FFF, answer reads with whatever the graphics-side bus presents.
- **Silent addresses.** Every other address gets no answer, and the CPU bus is left undriven.

While `cpu_mode` is high, the block copies the CPU bus onto the graphics-side bus. The one exception is a passthrough read, when the graphics side must be the one driving.

The block has no stream interfaces: every pin is a plain control or data line. It applies no back-pressure, and a master may issue one phase every cycle.

Top module: `bpr_ram_top`

## Requirements
- R1: A cycle with only `ph_addr` high captures `cpu_bus_i` as the current address at that clock edge. Later reads are served from that address.
- R2: A cycle with only `ph_write` high and a captured address in 0x0200–0x035F stores `cpu_bus_i` there. A later read of that address returns the stored word. After reset every stored word is 0x0000.
- R3: A read of a captured address in 0x0360–0x03FF drives 0xFFFF with `cpu_bus_oe` high.
- R4: A read of a captured address in 0x0000–0x007F or 0x3000–0x3FFF drives `gfx_bus_i` onto `cpu_bus_o` with `cpu_bus_oe` high.
- R5: A read of any other captured address (0x0080–0x01FF, 0x0400–0x2FFF, 0x4000–0xFFFF) leaves `cpu_bus_oe` low and `cpu_bus_o` at 0x0000.
- R6: A cycle with only `ph_comb` high captures `cpu_bus_i` as the new address, exactly as R1 does, and keeps `cpu_bus_oe` low in that cycle whatever the previous address was.
- R7: While `cpu_mode` is high, `gfx_bus_o` equals `cpu_bus_i` and `gfx_bus_oe` is high, except during a passthrough read (R4), when `gfx_bus_oe` is low. While `cpu_mode` is low, `gfx_bus_oe` is low.
- R8: A write to a captured address outside 0x0200–0x035F changes no stored word. For example, a write to 0x0360 still reads back as 0xFFFF.
- R9: A cycle with two or more strobes high is idle. It captures no address, stores nothing and drives `cpu_bus_oe` low.
- R10: `cpu_bus_oe` is high only in a cycle whose sole strobe is `ph_read` and whose captured address is in a responding range. Otherwise `cpu_bus_o` is 0x0000. Reset clears the captured address to 0x0000 and drives `cpu_bus_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_mode | input | 1 | High: mirror the CPU bus onto the graphics side |
| ph_addr | input | 1 | Address phase strobe |
| ph_read | input | 1 | Read phase strobe |
| ph_write | input | 1 | Write phase strobe |
| ph_comb | input | 1 | Combined phase strobe (captures an address only) |
| cpu_bus_i | input | 16 | Shared CPU address/data bus, incoming |
| cpu_bus_o | output | 16 | Read data toward the CPU bus |
| cpu_bus_oe | output | 1 | Drive enable for `cpu_bus_o` |
| gfx_bus_i | input | 16 | Graphics-side bus, incoming |
| gfx_bus_o | output | 16 | Mirrored word toward the graphics side |
| gfx_bus_oe | output | 1 | Drive enable for `gfx_bus_o` |

## Verification
The bench first walks the address decoder through the first and last word of every region boundary. This separates an off-by-one window edge from a true miss, and it separates the all-ones area from real storage. Next come the order-sensitive patterns. Writes followed by reads show that data lands at the captured word and nowhere else. A combined phase issued right after an in-range address separates "capture only" from "capture and drive". Overlapping strobes show that a collision neither moves the address nor stores anything. A long pseudo-random run of mixed phases, addresses and mode values then compares every output against the reference model on every cycle. This catches interactions between the passthrough read, the mirror enable and the storage window that the directed cases do not reach.

// File: rtl/bpr_pkg.sv
package bpr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_COMB,
    PH_READ,
    PH_WRITE
  } phase_t;

  typedef enum logic [1:0] {
    RG_NONE,
    RG_STORE,
    RG_BLANK,
    RG_PASS
  } region_t;
endpackage

// File: rtl/bpr_phase_dec.sv
module bpr_phase_dec
  import bpr_pkg::*;
(
  input  logic   ph_addr,
  input  logic   ph_read,
  input  logic   ph_write,
  input  logic   ph_comb,
  output phase_t phase
);
  logic [3:0] strobes;
  assign strobes = {ph_write, ph_read, ph_comb, ph_addr};

  // Exactly one strobe selects a phase; any collision is idle.
  always_comb begin
    phase = PH_IDLE;
    if ($countones(strobes) == 1) begin
      if (ph_addr)       phase = PH_ADDR;
      else if (ph_comb)  phase = PH_COMB;
      else if (ph_read)  phase = PH_READ;
      else               phase = PH_WRITE;
    end
  end
endmodule

// File: rtl/bpr_region_dec.sv
module bpr_region_dec
  import bpr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int RAM_BASE = 'h0200,
  parameter int RAM_SPAN = 'h0200,
  parameter int RAM_USED = 'h0160,
  parameter int NUM_PASS = 2,
  parameter logic [NUM_PASS*ADDR_W-1:0] PASS_BASES = {16'h3000, 16'h0000},
  parameter logic [NUM_PASS*ADDR_W-1:0] PASS_SPANS = {16'h1000, 16'h0080},
  localparam int IDX_W = $clog2(RAM_USED)
) (
  input  logic [ADDR_W-1:0] addr,
  output region_t           region,
  output logic [IDX_W-1:0]  store_idx
);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(RAM_BASE);
  localparam logic [ADDR_W-1:0] SPAN_V = ADDR_W'(RAM_SPAN);
  localparam logic [ADDR_W-1:0] USED_V = ADDR_W'(RAM_USED);

  logic [ADDR_W-1:0]   ram_off;
  logic                in_window;
  logic                in_used;
  logic [NUM_PASS-1:0] pass_hit;

  assign ram_off   = addr - BASE_V;
  assign in_window = (addr >= BASE_V) && (ram_off < SPAN_V);
  assign in_used   = in_window && (ram_off < USED_V);
  assign store_idx = ram_off[IDX_W-1:0];

  for (genvar g = 0; g < NUM_PASS; g++) begin : g_pass
    localparam logic [ADDR_W-1:0] PB = PASS_BASES[g*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] PS = PASS_SPANS[g*ADDR_W +: ADDR_W];
    logic [ADDR_W-1:0] off;
    assign off         = addr - PB;
    assign pass_hit[g] = (addr >= PB) && (off < PS);
  end

  always_comb begin
    if (in_used)        region = RG_STORE;
    else if (in_window) region = RG_BLANK;
    else if (|pass_hit) region = RG_PASS;
    else                region = RG_NONE;
  end
endmodule

// File: rtl/bpr_store.sv
module bpr_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 352,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = (int'(idx) < DEPTH) ? mem[idx] : '1;
endmodule

// File: rtl/bpr_ram_top.sv
module bpr_ram_top
  import bpr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int RAM_BASE = 'h0200,
  parameter int RAM_SPAN = 'h0200,
  parameter int RAM_USED = 'h0160,
  localparam int IDX_W   = $clog2(RAM_USED)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_mode,
  input  logic              ph_addr,
  input  logic              ph_read,
  input  logic              ph_write,
  input  logic              ph_comb,
  input  logic [DATA_W-1:0] cpu_bus_i,
  output logic [DATA_W-1:0] cpu_bus_o,
  output logic              cpu_bus_oe,
  input  logic [DATA_W-1:0] gfx_bus_i,
  output logic [DATA_W-1:0] gfx_bus_o,
  output logic              gfx_bus_oe
);
  phase_t            phase;
  region_t           region;
  logic [DATA_W-1:0] lat_addr;
  logic [IDX_W-1:0]  store_idx;
  logic [DATA_W-1:0] store_rdata;
  logic              store_we;
  logic              rd_hit;
  logic              pass_rd;

  bpr_phase_dec u_phase (
    .ph_addr (ph_addr),
    .ph_read (ph_read),
    .ph_write(ph_write),
    .ph_comb (ph_comb),
    .phase   (phase)
  );

  bpr_region_dec #(
    .ADDR_W  (DATA_W),
    .RAM_BASE(RAM_BASE),
    .RAM_SPAN(RAM_SPAN),
    .RAM_USED(RAM_USED)
  ) u_region (
    .addr     (lat_addr),
    .region   (region),
    .store_idx(store_idx)
  );

  bpr_store #(
    .DATA_W(DATA_W),
    .DEPTH (RAM_USED)
  ) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (store_we),
    .idx  (store_idx),
    .wdata(cpu_bus_i),
    .rdata(store_rdata)
  );

  // Both the address phase and the combined phase capture the bus word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_addr <= '0;
    else if (phase == PH_ADDR || phase == PH_COMB) lat_addr <= cpu_bus_i;
  end

  assign store_we = (phase == PH_WRITE) && (region == RG_STORE);
  assign rd_hit   = (phase == PH_READ) && (region != RG_NONE);
  assign pass_rd  = (phase == PH_READ) && (region == RG_PASS);

  always_comb begin
    cpu_bus_o = '0;
    if (rd_hit) begin
      unique case (region)
        RG_STORE: cpu_bus_o = store_rdata;
        RG_BLANK: cpu_bus_o = '1;
        RG_PASS:  cpu_bus_o = gfx_bus_i;
        default:  cpu_bus_o = '0;
      endcase
    end
  end
  assign cpu_bus_oe = rd_hit;

  // The graphics side stops receiving the mirror while it is being read.
  assign gfx_bus_o  = cpu_bus_i;
  assign gfx_bus_oe = cpu_mode && !pass_rd;
endmodule

// File: rtl/bpr_ram_chk.sv
module bpr_ram_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_mode,
  input logic              ph_addr,
  input logic              ph_read,
  input logic              ph_write,
  input logic              ph_comb,
  input logic [DATA_W-1:0] cpu_bus_i,
  input logic              cpu_bus_oe,
  input logic              gfx_bus_oe,
  input logic [DATA_W-1:0] lat_addr
);
  logic only_addr, only_comb, only_read, multi;
  logic lat_silent;
  assign only_addr  = ph_addr && !ph_read && !ph_write && !ph_comb;
  assign only_comb  = ph_comb && !ph_read && !ph_write && !ph_addr;
  assign only_read  = ph_read && !ph_addr && !ph_write && !ph_comb;
  assign multi      = $countones({ph_addr, ph_read, ph_write, ph_comb}) > 1;
  assign lat_silent = (lat_addr >= 16'h0080 && lat_addr < 16'h0200) ||
                      (lat_addr >= 16'h0400 && lat_addr < 16'h3000) ||
                      (lat_addr >= 16'h4000);

  AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    only_addr |=> lat_addr == $past(cpu_bus_i)); // R1
  AST_SILENT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (only_read && lat_silent) |-> !cpu_bus_oe); // R5
  AST_COMB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    only_comb |=> lat_addr == $past(cpu_bus_i)); // R6
  AST_COMB_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ph_comb |-> !cpu_bus_oe); // R6
  AST_MIRROR_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_mode && !ph_read) |-> gfx_bus_oe); // R7
  AST_MIRROR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_mode |-> !gfx_bus_oe); // R7
  AST_COLLIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    multi |=> $stable(lat_addr)); // R9
  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_bus_oe |-> only_read); // R10
endmodule

bind bpr_ram_top bpr_ram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_mode  (cpu_mode),
  .ph_addr   (ph_addr),
  .ph_read   (ph_read),
  .ph_write  (ph_write),
  .ph_comb   (ph_comb),
  .cpu_bus_i (cpu_bus_i),
  .cpu_bus_oe(cpu_bus_oe),
  .gfx_bus_oe(gfx_bus_oe),
  .lat_addr  (lat_addr)
);

// File: tb/bpr_ram_top_tb.sv
module bpr_ram_top_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cpu_mode = 0;
  logic        ph_addr = 0, ph_read = 0, ph_write = 0, ph_comb = 0;
  logic [15:0] cpu_bus_i = 0, gfx_bus_i = 0;
  logic [15:0] cpu_bus_o, gfx_bus_o;
  logic        cpu_bus_oe, gfx_bus_oe;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  int model_mem [352];
  int model_lat = 0;

  always #2 clk = ~clk;

  bpr_ram_top u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_mode(cpu_mode),
    .ph_addr(ph_addr), .ph_read(ph_read), .ph_write(ph_write), .ph_comb(ph_comb),
    .cpu_bus_i(cpu_bus_i), .cpu_bus_o(cpu_bus_o), .cpu_bus_oe(cpu_bus_oe),
    .gfx_bus_i(gfx_bus_i), .gfx_bus_o(gfx_bus_o), .gfx_bus_oe(gfx_bus_oe)
  );

  function automatic bit is_store(int a); return a >= 'h200 && a < 'h360; endfunction
  function automatic bit is_blank(int a); return a >= 'h360 && a < 'h400; endfunction
  function automatic bit is_pass(int a);
    return a < 'h80 || (a >= 'h3000 && a < 'h4000);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One bus cycle: drive at the falling edge, compare, then advance the model.
  task automatic step(bit a, bit c, bit r, bit w, int bus, int gfx, bit mode, string tag);
    int  n;
    bit  one;
    int  e_o, e_oe, e_goe;
    @(negedge clk);
    ph_addr = a; ph_comb = c; ph_read = r; ph_write = w;
    cpu_bus_i = bus[15:0]; gfx_bus_i = gfx[15:0]; cpu_mode = mode;
    #1;
    n   = int'(a) + int'(c) + int'(r) + int'(w);
    one = (n == 1);
    e_o = 0; e_oe = 0;
    if (one && r) begin
      if (is_store(model_lat))      begin e_o = model_mem[model_lat - 'h200]; e_oe = 1; end
      else if (is_blank(model_lat)) begin e_o = 'hFFFF; e_oe = 1; end
      else if (is_pass(model_lat))  begin e_o = gfx & 'hFFFF; e_oe = 1; end
    end
    e_goe = (mode && !(one && r && is_pass(model_lat))) ? 1 : 0;
    check(tag, "cpu_bus_oe", int'(cpu_bus_oe), e_oe);
    check(tag, "cpu_bus_o", int'(cpu_bus_o), e_o);
    check(tag, "gfx_bus_oe", int'(gfx_bus_oe), e_goe);
    check("R7", "gfx_bus_o", int'(gfx_bus_o), bus & 'hFFFF);
    @(posedge clk);
    if (one && (a || c)) model_lat = bus & 'hFFFF;
    if (one && w && is_store(model_lat)) model_mem[model_lat - 'h200] = bus & 'hFFFF;
  endtask

  task automatic latch(int addr, string tag); step(1, 0, 0, 0, addr, 'h0, 1, tag); endtask
  task automatic wr(int d, string tag);       step(0, 0, 0, 1, d, 'h0, 1, tag); endtask
  task automatic rd(int gfx, string tag);     step(0, 0, 1, 0, 'h0, gfx, 1, tag); endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      misses++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    int lfsr;
    int pick;
    int addrs [12];
    foreach (model_mem[i]) model_mem[i] = 0;
    #5;
    // Reset state: no drive on the CPU side.
    check("R10", "reset cpu_bus_oe", int'(cpu_bus_oe), 0);
    check("R10", "reset gfx_bus_oe", int'(gfx_bus_oe), 0);
    @(negedge clk); rst_n = 1;

    // Captured address after reset is 0x0000, a passthrough word.
    rd('h1357, "R10");

    // Storage window edges.
    latch('h0200, "R1"); wr('h1234, "R2");
    latch('h035F, "R1"); wr('hBEEF, "R2");
    latch('h0201, "R1"); wr('h0F0F, "R2");
    latch('h0200, "R1"); rd('h0, "R2");
    latch('h035F, "R1"); rd('h0, "R2");
    latch('h0300, "R2"); rd('h0, "R2");

    // All-ones area and ignored writes.
    latch('h0360, "R3"); rd('h0, "R3");
    wr('h5555, "R8"); rd('h0, "R8");
    latch('h03FF, "R3"); rd('h0, "R3");
    latch('h3000, "R8"); wr('h7777, "R8");
    latch('h0200, "R8"); rd('h0, "R8");

    // Passthrough windows.
    latch('h007F, "R4"); rd('hA5A5, "R4");
    latch('h3000, "R4"); rd('h5A5A, "R4");
    latch('h3FFF, "R4"); rd('hC3C3, "R4");

    // Silent addresses.
    addrs = '{'h0080, 'h01FF, 'h0400, 'h2FFF, 'h4000, 'hFFFF,
              'h0080, 'h0080, 'h0080, 'h0080, 'h0080, 'h0080};
    for (int i = 0; i < 6; i++) begin latch(addrs[i], "R5"); rd('h9999, "R5"); end

    // Combined phase: captures, never drives.
    latch('h0200, "R6");
    step(0, 1, 0, 0, 'h0201, 'h0, 1, "R6");
    rd('h0, "R6");
    step(0, 1, 0, 0, 'h0080, 'h0, 1, "R6");
    rd('h0, "R6");

    // Collisions are idle.
    latch('h0200, "R9");
    step(1, 0, 1, 0, 'h3000, 'h1111, 1, "R9");
    rd('h2222, "R9");
    step(0, 0, 1, 1, 'h9999, 'h0, 1, "R9");
    step(0, 1, 0, 1, 'h0360, 'h0, 1, "R9");
    rd('h0, "R9");

    // Mirror disabled.
    step(0, 0, 0, 0, 'hABCD, 'h0, 0, "R7");
    latch('h3000, "R7");
    step(0, 0, 1, 0, 'h0, 'h4444, 0, "R7");

    // Mixed pseudo-random traffic.
    lfsr = 'h1ACE;
    for (int k = 0; k < 3000; k++) begin
      lfsr = ((lfsr << 1) ^ (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 'hFFFF;
      pick = lfsr % 8;
      case (pick)
        0, 1: step(1, 0, 0, 0, (lfsr & 1) ? ('h0200 + (lfsr % 'h200)) : (lfsr * 7) & 'hFFFF,
                   'h0, lfsr[3], "R1");
        2:    step(0, 1, 0, 0, 'h0200 + (lfsr % 'h180), 'h0, lfsr[3], "R6");
        3, 4: step(0, 0, 1, 0, 'h0, lfsr ^ 'h5A5A, lfsr[2], "R4");
        5:    step(0, 0, 0, 1, lfsr ^ 'h00FF, 'h0, lfsr[4], "R2");
        6:    step(lfsr[5], lfsr[6], 1, lfsr[7], lfsr, lfsr, 1, "R9");
        default: step(0, 0, 0, 0, lfsr, 'h0, lfsr[1], "R7");
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule